// File: doc/BRIEF.md
# Four-Channel Periodic Countdown Timer

The block holds a small set of independent countdown channels that share one timebase tick. Each channel has a load register and a down-counter of equal width. While a channel runs, which needs both its own enable and the global enable, every cycle with the tick high lowers its counter by one. A tick that finds the counter at zero reloads it from the load register and raises the channel's time-out flag. With a load value of N, a channel therefore expires once every N+1 ticks.

Software reaches the block through a flat register bus. Writes take effect on the clock edge that samples `bus_wr`, and reads are combinational from `bus_addr`. Software can start a channel, force an immediate reload, mask each channel's interrupt, and acknowledge flags by writing ones. Each flag and each interrupt is also driven on its own output pin.

Register map (word addresses, data in the low bits): 0 global control (bit 0 = global enable), 1 channel enables (bit i = channel i), 2 force-reload strobes (bit i = channel i), 3 time-out flags (bit i = channel i, write one to clear), 4 interrupt enables (bit i = channel i), 8+i load register of channel i, 12+i counter of channel i (read only). Unmapped addresses and unused bits read as zero.

Top module: `cdt_top`

## Requirements
- R1: After reset every register reads zero, and the flag and interrupt outputs are low.
- R2: On the clock edge where a channel goes from stopped to running (its enable bit set while the global enable is set, or the global enable set while its enable bit is set), its counter is loaded from its load register.
- R3: A running channel whose counter is not zero decrements by exactly one on each edge with tick high, and holds on edges with tick low.
- R4: A running channel whose counter is zero, on an edge with tick high, reloads its counter from the load register and sets its time-out flag.
- R5: A channel whose own enable or the global enable is clear keeps its counter unchanged, ticks or not.
- R6: Writing a one to bit i of the force-reload register copies load register i into counter i when channel i is running. Bits written as zero, and all bits of a stopped channel, have no effect.
- R7: The force-reload register always reads zero. Channel-enable bits above the channel count read zero whatever is written.
- R8: Clearing a channel's enable bit clears its time-out flag on the same edge, and the flag stays clear while the channel is disabled.
- R9: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R10: When a time-out and a write-one-to-clear of the same flag happen on the same edge, the flag ends set.
- R11: Interrupt output i is high exactly when flag i and interrupt-enable bit i are both set.
- R12: Channels run independently: several channels with different load values count and expire each on their own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Shared timebase tick, one count per high cycle |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| tmo_flag | output | 4 | Time-out flag per channel |
| irq | output | 4 | Interrupt per channel, flag gated by its enable |

## Verification
The bench aims at the edges where two causes meet. A time-out and a flag clear land on the same edge; a design that lets the clear win loses an interrupt. A force-reload is issued while the global enable is off; a design that ignores the gating rewrites the counter of a stopped channel. Turning the global enable back on with the channel enable still set must restart the channel; a design that only watches the channel-enable write leaves the stale count in place. A channel with load value zero must expire on every tick, and disabling a channel must drop its pending flag; designs that get either wrong show a wrong period or a flag that survives the disable.

// File: rtl/cdt_pkg.sv
// Shared constants of the countdown timer: the register word addresses.
// Assumes a bus address of at least four bits and at most four channels.
package cdt_pkg;
    localparam int A_CTRL      = 0;
    localparam int A_CHEN      = 1;
    localparam int A_FORCE     = 2;
    localparam int A_FLAG      = 3;
    localparam int A_IEN       = 4;
    localparam int A_LOAD_BASE = 8;
    localparam int A_CNT_BASE  = 12;
endpackage

// File: rtl/cdt_regs.sv
// Register file and bus decode of the countdown timer.
// Holds the global enable, channel enables, interrupt enables and load
// registers, and turns bus writes into per-channel start, force-reload
// and flag-clear strobes. Assumes CW <= DW and NCH <= 4.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NCH-1:0]          flags,
    input  logic [NCH-1:0][CW-1:0]  cnt,
    output logic [NCH-1:0]          ch_en,
    output logic [NCH-1:0]          ch_en_nxt,
    output logic [NCH-1:0]          run,
    output logic [NCH-1:0]          ie,
    output logic [NCH-1:0][CW-1:0]  load,
    output logic [NCH-1:0]          start,
    output logic [NCH-1:0]          force_ld,
    output logic [NCH-1:0]          flag_clr
);
    logic glb_en;
    logic glb_en_nxt;

    // Next values of the enables, to see a channel starting on this edge
    always_comb begin
        glb_en_nxt = glb_en;
        ch_en_nxt  = ch_en;
        if (bus_wr && bus_addr == AW'(A_CTRL)) glb_en_nxt = bus_wdata[0];
        if (bus_wr && bus_addr == AW'(A_CHEN)) ch_en_nxt  = bus_wdata[NCH-1:0];
    end

    // Run state now, and strobes derived from the current write
    always_comb begin
        run      = {NCH{glb_en}} & ch_en;
        start    = {NCH{glb_en_nxt}} & ch_en_nxt & ~run;
        force_ld = (bus_wr && bus_addr == AW'(A_FORCE)) ? (bus_wdata[NCH-1:0] & run) : '0;
        flag_clr = (bus_wr && bus_addr == AW'(A_FLAG))  ? bus_wdata[NCH-1:0] : '0;
    end

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
            ch_en  <= '0;
            ie     <= '0;
            load   <= '0;
        end else begin
            glb_en <= glb_en_nxt;
            ch_en  <= ch_en_nxt;
            if (bus_wr && bus_addr == AW'(A_IEN)) ie <= bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_wr && bus_addr == AW'(A_LOAD_BASE + i))
                    load[i] <= bus_wdata[CW-1:0];
            end
        end
    end

    // Read multiplexer; the force-reload address falls to the zero default
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_CTRL)) bus_rdata[0]       = glb_en;
        if (bus_addr == AW'(A_CHEN)) bus_rdata[NCH-1:0] = ch_en;
        if (bus_addr == AW'(A_FLAG)) bus_rdata[NCH-1:0] = flags;
        if (bus_addr == AW'(A_IEN))  bus_rdata[NCH-1:0] = ie;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(A_LOAD_BASE + i)) bus_rdata[CW-1:0] = load[i];
            if (bus_addr == AW'(A_CNT_BASE + i))  bus_rdata[CW-1:0] = cnt[i];
        end
    end
endmodule

// File: rtl/cdt_channel.sv
// One countdown channel: a down-counter with reload and a time-out flag.
// A load request (start or force) wins over counting on the same edge.
// The flag is held clear while the channel's next enable is clear, and a
// time-out wins over a flag clear on the same edge.
module cdt_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en_nxt,
    input  logic          tick,
    input  logic          load_now,
    input  logic [CW-1:0] load_val,
    input  logic          flag_clr,
    output logic [CW-1:0] cnt,
    output logic          flag
);
    logic expire;

    // Time-out condition: running, ticking, at zero, no load pending
    assign expire = run && tick && !load_now && (cnt == '0);

    // Counter: load, reload on time-out, or decrement on tick
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load_now)       cnt <= load_val;
        else if (expire)         cnt <= load_val;
        else if (run && tick)    cnt <= cnt - CW'(1);
    end

    // Flag: cleared by disable, set by time-out, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!en_nxt)   flag <= 1'b0;
        else if (expire)    flag <= 1'b1;
        else if (flag_clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/cdt_top.sv
// Countdown timer top: register file plus one channel per generate slot.
// Assumes a single clock domain and a tick input already synchronous.
module cdt_top #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] tmo_flag,
    output logic [NCH-1:0] irq
);
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         ch_en_nxt;
    logic [NCH-1:0]         run;
    logic [NCH-1:0]         ie;
    logic [NCH-1:0][CW-1:0] load_vec;
    logic [NCH-1:0][CW-1:0] cnt_vec;
    logic [NCH-1:0]         start;
    logic [NCH-1:0]         force_ld;
    logic [NCH-1:0]         flag_clr;

    cdt_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flags(tmo_flag), .cnt(cnt_vec),
        .ch_en(ch_en), .ch_en_nxt(ch_en_nxt), .run(run), .ie(ie), .load(load_vec),
        .start(start), .force_ld(force_ld), .flag_clr(flag_clr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cdt_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .run(run[g]), .en_nxt(ch_en_nxt[g]), .tick(tick),
            .load_now(start[g] | force_ld[g]), .load_val(load_vec[g]),
            .flag_clr(flag_clr[g]),
            .cnt(cnt_vec[g]), .flag(tmo_flag[g])
        );
    end

    // Interrupts: flag gated by its enable
    assign irq = tmo_flag & ie;
endmodule

// File: rtl/cdt_checker.sv
// Protocol checks for the countdown timer, bound onto cdt_top.
module cdt_checker
    import cdt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input logic                   bus_wr,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         tmo_flag,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         ch_en,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0][CW-1:0] cnt_vec,
    input logic [NCH-1:0][CW-1:0] load_vec
);
    assert_force_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == AW'(A_FORCE) |-> bus_rdata == '0);

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~tmo_flag) == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_disabled_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |-> !tmo_flag[g]);

        assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !bus_wr) |=> $stable(cnt_vec[g]));

        assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && tick && !bus_wr && cnt_vec[g] != '0)
                |=> cnt_vec[g] == $past(cnt_vec[g]) - CW'(1));

        assert_reload_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && tick && !bus_wr && cnt_vec[g] == '0)
                |=> (tmo_flag[g] && cnt_vec[g] == $past(load_vec[g])));
    end
endmodule

bind cdt_top cdt_checker #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .tmo_flag(tmo_flag), .irq(irq), .ch_en(ch_en),
    .run(run), .cnt_vec(cnt_vec), .load_vec(load_vec)
);

// File: tb/cdt_top_test.sv
// Directed bench for cdt_top: one task per scenario, each checking itself.
module cdt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  tmo_flag;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    cdt_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmo_flag(tmo_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 register reset", v, 16'h0);
        end
        chk("R1 flag pins", {12'h0, tmo_flag}, 16'h0);
        chk("R1 irq pins", {12'h0, irq}, 16'h0);
    endtask

    task automatic t_start_and_count;
        logic [15:0] v;
        wr(4'd8, 16'd5);
        wr(4'd0, 16'd1);
        wr(4'd1, 16'd1);
        rd(4'd12, v); chk("R2 load on start", v, 16'd5);
        ticks(3);
        rd(4'd12, v); chk("R3 three ticks", v, 16'd2);
        repeat (2) @(negedge clk);
        rd(4'd12, v); chk("R3 hold without tick", v, 16'd2);
    endtask

    task automatic t_expire;
        logic [15:0] v;
        ticks(2);
        rd(4'd12, v); chk("R3 reach zero", v, 16'd0);
        chk("R4 no flag at zero", {12'h0, tmo_flag}, 16'h0);
        ticks(1);
        rd(4'd12, v); chk("R4 reload", v, 16'd5);
        rd(4'd3, v);  chk("R4 flag set", v, 16'h1);
        chk("R11 masked irq", {12'h0, irq}, 16'h0);
        wr(4'd4, 16'h1);
        chk("R11 irq enabled", {12'h0, irq}, 16'h1);
    endtask

    task automatic t_flag_clear;
        logic [15:0] v;
        wr(4'd3, 16'h0);
        rd(4'd3, v); chk("R9 write zero keeps flag", v, 16'h1);
        wr(4'd3, 16'h1);
        rd(4'd3, v); chk("R9 write one clears", v, 16'h0);
        chk("R11 irq drops", {12'h0, irq}, 16'h0);
    endtask

    task automatic t_multi;
        logic [15:0] v;
        wr(4'd9, 16'd3);
        wr(4'd10, 16'd1);
        wr(4'd1, 16'h7);
        ticks(2);
        rd(4'd13, v); chk("R12 ch1 count", v, 16'd1);
        rd(4'd14, v); chk("R12 ch2 reloaded", v, 16'd1);
        rd(4'd3, v);  chk("R12 only ch2 flag", v & 16'h6, 16'h4);
        wr(4'd1, 16'h1);
        rd(4'd3, v);  chk("R8 flags cleared on disable", v & 16'h6, 16'h0);
    endtask

    task automatic t_same_edge;
        logic [15:0] v;
        wr(4'd3, 16'hF);
        wr(4'd8, 16'd0);
        wr(4'd2, 16'h1);
        rd(4'd12, v); chk("R6 force to zero", v, 16'd0);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 16'h1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(4'd3, v); chk("R10 set wins over clear", v & 16'h1, 16'h1);
        wr(4'd3, 16'h1);
        rd(4'd3, v); chk("R10 later clear", v & 16'h1, 16'h0);
    endtask

    task automatic t_force;
        logic [15:0] v;
        wr(4'd8, 16'd7);
        wr(4'd2, 16'h1);
        rd(4'd12, v); chk("R6 force one", v, 16'd7);
        wr(4'd8, 16'd4);
        wr(4'd2, 16'h0);
        rd(4'd12, v); chk("R6 force zero ignored", v, 16'd7);
        wr(4'd0, 16'h0);
        wr(4'd8, 16'd9);
        wr(4'd2, 16'h1);
        rd(4'd12, v); chk("R6 force ignored module off", v, 16'd7);
        ticks(3);
        rd(4'd12, v); chk("R5 hold module off", v, 16'd7);
        wr(4'd0, 16'h1);
        rd(4'd12, v); chk("R2 start on module enable", v, 16'd9);
    endtask

    task automatic t_readback;
        logic [15:0] v;
        wr(4'd2, 16'hF);
        rd(4'd2, v); chk("R7 force reads zero", v, 16'h0);
        wr(4'd1, 16'hFF);
        rd(4'd1, v); chk("R7 enable upper bits", v, 16'h0F);
        wr(4'd1, 16'h1);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        wr(4'd8, 16'd0);
        wr(4'd2, 16'h1);
        ticks(1);
        rd(4'd3, v); chk("R4 zero load expires", v & 16'h1, 16'h1);
        wr(4'd8, 16'd6);
        wr(4'd2, 16'h1);
        wr(4'd1, 16'h0);
        rd(4'd3, v); chk("R8 disable clears flag", v, 16'h0);
        chk("R8 flag pin", {12'h0, tmo_flag}, 16'h0);
        ticks(4);
        rd(4'd12, v); chk("R5 hold channel off", v, 16'd6);
        wr(4'd2, 16'h1);
        rd(4'd12, v); chk("R6 force ignored channel off", v, 16'd6);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_start_and_count;
        t_expire;
        t_flag_clear;
        t_multi;
        t_same_edge;
        t_force;
        t_readback;
        t_disable;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule